// File: doc/BRIEF.md
# Three-Tier Port Arbiter

This block selects which of eight request ports a memory controller serves next. The ports fall into three tiers. Ports 0 and 1 form the top tier. Ports 2 and 3 form the middle tier. Ports 4 to 7 form the bottom tier. A request from any higher tier always beats every lower tier. Inside a tier, fairness comes from a small per-tier memory that records the port served last. The two-port tiers alternate between their two ports. The four-port tier rotates upward through 4, 5, 6, 7 and then wraps back to 4.

Each port carries a 2-bit access mode. One mode marks an older-style requester, another marks a newer-style requester, and the two remaining codes lock the port out. The arbiter decides only while the controller reports that it is idle. It registers a one-hot grant, the number of the granted port and that port's mode. It holds all of these until the controller pulses cycle-done. The per-tier last-served indices are brought out so the controller and a maintenance display can see the fairness state.

Top module: `tier_port_arbiter`

## Requirements
- R1: After reset, `grantValid` is 0, `grantVec` is all zero, `lastTop` is 1, `lastMid` is 1 and `lastLow` is 3. With these values, port 0, port 2 and port 4 are each first in line within their tiers.
- R2: A grant is captured only on a clock edge where `ctrlIdle` is 1, no grant is outstanding, and at least one eligible request exists. `grantValid` and the grant outputs appear in the cycle after that edge.
- R3: Once a grant is issued, `grantVec`, `grantPort` and `grantMode` stay stable until a clock edge with `cycleDone` high. After that edge, `grantValid` is 0 and `grantVec` is zero.
- R4: Any eligible request on port 0 or 1 beats every request on ports 2 to 7. Any eligible request on port 2 or 3 beats every request on ports 4 to 7.
- R5: When ports 0 and 1 are both eligible, the port not recorded in `lastTop` wins.
- R6: When ports 2 and 3 are both eligible, the port not recorded in `lastMid` wins. `lastMid` holds 0 for port 2 and 1 for port 3.
- R7: In the bottom tier, the search starts at the port after the one recorded in `lastLow` and moves upward, wrapping from 7 to 4. `lastLow` holds the port number minus 4.
- R8: A port whose mode field (bits 2p+1:2p of `portMode`) is 2'b00 or 2'b11 is never granted, even while it requests.
- R9: The mode codes 2'b01 (older style) and 2'b10 (newer style) make a port eligible. `grantPort` gives the index of the granted port, and `grantMode` gives that port's mode as sampled at the capture edge.
- R10: A tier's last-served index changes only when that tier wins a grant. It then takes the in-tier index of the winner.
- R11: `grantVec` is one-hot while `grantValid` is 1 and all zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 8 | Request, one bit per port |
| portMode | input | 16 | Two-bit access mode per port, port p at bits 2p+1:2p |
| ctrlIdle | input | 1 | Controller is free to start a cycle |
| cycleDone | input | 1 | Pulse that ends the outstanding grant |
| grantValid | output | 1 | A grant is outstanding |
| grantVec | output | 8 | One-hot grant |
| grantPort | output | 3 | Index of the granted port |
| grantMode | output | 2 | Mode of the granted port |
| lastTop | output | 1 | Last-served index within ports 0..1 |
| lastMid | output | 1 | Last-served index within ports 2..3 |
| lastLow | output | 2 | Last-served index within ports 4..7 |

## Verification
The bench sweeps all 256 request patterns twice: once with every port enabled, and once with mixed and locked-out modes. A model in the bench tracks the three fairness pointers, so the sweep covers contested pairs, the wrap from port 7 back to port 4, and locked-out ports sitting next to live ones. Some faults would show up directly. An arbiter that updated every pointer on each grant would break the alternation of a tier that lost. A search that started at the last-served port would serve the same bottom-tier port twice. A design that took the mode as a request would grant a locked-out port. Directed cases also raise higher-tier requests while a grant is outstanding and while `ctrlIdle` is low. A design that re-arbitrated in those windows would move the grant.

// File: rtl/tier_arb_pkg.sv
`timescale 1ns/1ps
package tier_arb_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_LEGACY = 2'b01,
    MODE_FULL   = 2'b10,
    MODE_LOCK   = 2'b11
  } portMode_t;

  typedef struct packed {
    logic capture;
    logic drop;
  } arbStrobe_t;
endpackage

// File: rtl/tier_rr_pick.sv
`timescale 1ns/1ps
module tier_rr_pick #(
  parameter int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] lastIdx,
  output logic [N-1:0]  winVec,
  output logic [IW-1:0] winIdx,
  output logic          anyReq
);
  always_comb begin
    int idx;
    logic found;
    found  = 1'b0;
    winVec = '0;
    winIdx = lastIdx;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(lastIdx) + k) % N;
      if (!found && req[idx]) begin
        found       = 1'b1;
        winVec[idx] = 1'b1;
        winIdx      = IW'(idx);
      end
    end
    anyReq = found;
  end
endmodule

// File: rtl/tier_arb_ctrl.sv
`timescale 1ns/1ps
module tier_arb_ctrl
  import tier_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlIdle,
  input  logic       cycleDone,
  input  logic       anyElig,
  output arbStrobe_t strobe,
  output logic       busy
);
  logic busyQ;

  always_comb begin
    strobe.capture = !busyQ && ctrlIdle && anyElig;
    strobe.drop    = busyQ && cycleDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              busyQ <= 1'b0;
    else if (strobe.capture) busyQ <= 1'b1;
    else if (strobe.drop)    busyQ <= 1'b0;
  end

  assign busy = busyQ;
endmodule

// File: rtl/tier_arb_datapath.sv
`timescale 1ns/1ps
module tier_arb_datapath
  import tier_arb_pkg::*;
#(
  parameter int TOP_PORTS = 2,
  parameter int MID_PORTS = 2,
  parameter int LOW_PORTS = 4,
  parameter int MODE_W    = 2,
  localparam int NUM_PORTS = TOP_PORTS + MID_PORTS + LOW_PORTS,
  localparam int PORT_W    = $clog2(NUM_PORTS),
  localparam int TOP_W     = $clog2(TOP_PORTS),
  localparam int MID_W     = $clog2(MID_PORTS),
  localparam int LOW_W     = $clog2(LOW_PORTS),
  localparam int MID_BASE  = TOP_PORTS,
  localparam int LOW_BASE  = TOP_PORTS + MID_PORTS
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        reqIn,
  input  logic [NUM_PORTS*MODE_W-1:0] portMode,
  input  arbStrobe_t                  strobe,
  output logic                        anyElig,
  output logic [NUM_PORTS-1:0]        grantVec,
  output logic [PORT_W-1:0]           grantPort,
  output logic [MODE_W-1:0]           grantMode,
  output logic [TOP_W-1:0]            lastTop,
  output logic [MID_W-1:0]            lastMid,
  output logic [LOW_W-1:0]            lastLow
);
  logic [NUM_PORTS-1:0] elig;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_elig
    logic [MODE_W-1:0] modeP;
    assign modeP   = portMode[p*MODE_W +: MODE_W];
    assign elig[p] = reqIn[p] &&
                     (modeP == MODE_W'(MODE_LEGACY) || modeP == MODE_W'(MODE_FULL));
  end

  logic [TOP_PORTS-1:0] topVec;
  logic [MID_PORTS-1:0] midVec;
  logic [LOW_PORTS-1:0] lowVec;
  logic [TOP_W-1:0]     topIdx;
  logic [MID_W-1:0]     midIdx;
  logic [LOW_W-1:0]     lowIdx;
  logic                 topAny, midAny, lowAny;
  logic [TOP_W-1:0]     lastTopQ;
  logic [MID_W-1:0]     lastMidQ;
  logic [LOW_W-1:0]     lastLowQ;

  tier_rr_pick #(.N(TOP_PORTS)) topPick_i (
    .req(elig[TOP_PORTS-1:0]), .lastIdx(lastTopQ),
    .winVec(topVec), .winIdx(topIdx), .anyReq(topAny));

  tier_rr_pick #(.N(MID_PORTS)) midPick_i (
    .req(elig[MID_BASE +: MID_PORTS]), .lastIdx(lastMidQ),
    .winVec(midVec), .winIdx(midIdx), .anyReq(midAny));

  tier_rr_pick #(.N(LOW_PORTS)) lowPick_i (
    .req(elig[LOW_BASE +: LOW_PORTS]), .lastIdx(lastLowQ),
    .winVec(lowVec), .winIdx(lowIdx), .anyReq(lowAny));

  logic [NUM_PORTS-1:0] nextVec;
  logic [PORT_W-1:0]    nextPort;

  always_comb begin
    nextVec  = '0;
    nextPort = '0;
    if (topAny) begin
      nextVec[TOP_PORTS-1:0] = topVec;
      nextPort               = PORT_W'(topIdx);
    end else if (midAny) begin
      nextVec[MID_BASE +: MID_PORTS] = midVec;
      nextPort = PORT_W'(MID_BASE) + PORT_W'(midIdx);
    end else if (lowAny) begin
      nextVec[LOW_BASE +: LOW_PORTS] = lowVec;
      nextPort = PORT_W'(LOW_BASE) + PORT_W'(lowIdx);
    end
  end

  assign anyElig = topAny || midAny || lowAny;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantVec  <= '0;
      grantPort <= '0;
      grantMode <= '0;
      lastTopQ  <= TOP_W'(TOP_PORTS - 1);
      lastMidQ  <= MID_W'(MID_PORTS - 1);
      lastLowQ  <= LOW_W'(LOW_PORTS - 1);
    end else if (strobe.capture) begin
      grantVec  <= nextVec;
      grantPort <= nextPort;
      grantMode <= portMode[MODE_W*nextPort +: MODE_W];
      if (topAny)      lastTopQ <= topIdx;
      else if (midAny) lastMidQ <= midIdx;
      else if (lowAny) lastLowQ <= lowIdx;
    end else if (strobe.drop) begin
      grantVec  <= '0;
      grantPort <= '0;
      grantMode <= '0;
    end
  end

  assign lastTop = lastTopQ;
  assign lastMid = lastMidQ;
  assign lastLow = lastLowQ;
endmodule

// File: rtl/tier_port_arbiter.sv
`timescale 1ns/1ps
module tier_port_arbiter
  import tier_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  reqIn,
  input  logic [15:0] portMode,
  input  logic        ctrlIdle,
  input  logic        cycleDone,
  output logic        grantValid,
  output logic [7:0]  grantVec,
  output logic [2:0]  grantPort,
  output logic [1:0]  grantMode,
  output logic        lastTop,
  output logic        lastMid,
  output logic [1:0]  lastLow
);
  arbStrobe_t strobe;
  logic       anyElig;

  tier_arb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlIdle(ctrlIdle), .cycleDone(cycleDone),
    .anyElig(anyElig), .strobe(strobe), .busy(grantValid));

  tier_arb_datapath #(
    .TOP_PORTS(2), .MID_PORTS(2), .LOW_PORTS(4), .MODE_W(2)
  ) dp_i (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .portMode(portMode),
    .strobe(strobe), .anyElig(anyElig), .grantVec(grantVec),
    .grantPort(grantPort), .grantMode(grantMode),
    .lastTop(lastTop), .lastMid(lastMid), .lastLow(lastLow));
endmodule

// File: rtl/tier_arb_chk.sv
`timescale 1ns/1ps
module tier_arb_chk
  import tier_arb_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  reqIn,
  input logic [15:0] portMode,
  input logic        ctrlIdle,
  input logic        cycleDone,
  input logic        grantValid,
  input logic [7:0]  grantVec,
  input logic [2:0]  grantPort,
  input logic [1:0]  grantMode,
  input logic        lastTop,
  input logic        lastMid,
  input logic [1:0]  lastLow
);
  logic [7:0] eligNow, eligPrev;

  always_comb begin
    for (int p = 0; p < 8; p++)
      eligNow[p] = reqIn[p] && (portMode[2*p +: 2] == 2'b01 || portMode[2*p +: 2] == 2'b10);
  end

  always_ff @(posedge clk) begin
    if (!rstN) eligPrev <= '0;
    else       eligPrev <= eligNow;
  end

  // R11
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> $onehot(grantVec));

  // R11
  grant_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> grantVec == 8'h00);

  // R3
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && !cycleDone |=> grantValid && $stable(grantVec) && $stable(grantPort) && $stable(grantMode));

  // R3
  grant_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && cycleDone |=> !grantValid);

  // R2
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantValid) |-> $past(ctrlIdle));

  // R8
  denied_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantValid) |-> (grantVec & ~eligPrev) == 8'h00);

  // R4
  top_tier_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantValid) && (|eligPrev[1:0]) |-> (|grantVec[1:0]));

  // R4
  mid_tier_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantValid) && !(|eligPrev[1:0]) && (|eligPrev[3:2]) |-> (|grantVec[3:2]));

  // R9
  port_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> grantVec[grantPort]);

  // R10
  last_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(grantValid) |-> $stable(lastTop) && $stable(lastMid) && $stable(lastLow));
endmodule

bind tier_port_arbiter tier_arb_chk chk_i (.*);

// File: tb/tier_port_arbiter_tb_top.sv
`timescale 1ns/1ps
module tier_port_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  reqIn;
  logic [15:0] portMode;
  logic        ctrlIdle;
  logic        cycleDone;
  logic        grantValid;
  logic [7:0]  grantVec;
  logic [2:0]  grantPort;
  logic [1:0]  grantMode;
  logic        lastTop;
  logic        lastMid;
  logic [1:0]  lastLow;

  int checks = 0;
  int fails  = 0;
  int mTop, mMid, mLow;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tier_port_arbiter dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit eligOf(input logic [7:0] r, input logic [15:0] m, input int p);
    return r[p] && (m[2*p +: 2] == 2'b01 || m[2*p +: 2] == 2'b10);
  endfunction

  // Returns winning port or -1.
  function automatic int expWin(input logic [7:0] r, input logic [15:0] m);
    bit e0 = eligOf(r, m, 0), e1 = eligOf(r, m, 1);
    bit e2 = eligOf(r, m, 2), e3 = eligOf(r, m, 3);
    if (e0 && e1) return (mTop == 1) ? 0 : 1;
    if (e0) return 0;
    if (e1) return 1;
    if (e2 && e3) return (mMid == 1) ? 2 : 3;
    if (e2) return 2;
    if (e3) return 3;
    for (int k = 1; k <= 4; k++) begin
      int idx = (mLow + k) % 4;
      if (eligOf(r, m, 4 + idx)) return 4 + idx;
    end
    return -1;
  endfunction

  task automatic checkLast(input string tag);
    chk({tag, " lastTop"}, int'(lastTop), mTop);
    chk({tag, " lastMid"}, int'(lastMid), mMid);
    chk({tag, " lastLow"}, int'(lastLow), mLow);
  endtask

  task automatic arbOnce(input logic [7:0] r, input logic [15:0] m, input string tag);
    int w;
    @(negedge clk);
    reqIn = r; portMode = m; ctrlIdle = 1'b1; cycleDone = 1'b0;
    w = expWin(r, m);
    @(negedge clk);
    chk({tag, " R2 grantValid"}, int'(grantValid), (w >= 0) ? 1 : 0);
    if (w >= 0) begin
      chk({tag, " R11 grantVec"}, int'(grantVec), 1 << w);
      chk({tag, " R9 grantPort"}, int'(grantPort), w);
      chk({tag, " R9 grantMode"}, int'(grantMode), int'(m[2*w +: 2]));
      if (w < 2) mTop = w; else if (w < 4) mMid = w - 2; else mLow = w - 4;
      checkLast({tag, " R10"});
      cycleDone = 1'b1; ctrlIdle = 1'b0;
      @(negedge clk);
      chk({tag, " R3 drop"}, int'(grantValid), 0);
      chk({tag, " R3 vec cleared"}, int'(grantVec), 0);
      cycleDone = 1'b0;
    end else begin
      chk({tag, " R8 no grant vec"}, int'(grantVec), 0);
      ctrlIdle = 1'b0;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqIn = '0; portMode = '0; ctrlIdle = 1'b0; cycleDone = 1'b0;
    mTop = 1; mMid = 1; mLow = 3;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 grantValid", int'(grantValid), 0);
    chk("R1 grantVec", int'(grantVec), 0);
    checkLast("R1");
    rstN = 1'b1;

    // R5 alternation in top tier
    for (int i = 0; i < 4; i++) arbOnce(8'h03, 16'hAAAA, "R5 pair0");
    // R6 alternation in middle tier
    for (int i = 0; i < 4; i++) arbOnce(8'h0C, 16'h5555, "R6 pair1");
    // R7 rotation and wrap in bottom tier
    for (int i = 0; i < 5; i++) arbOnce(8'hF0, 16'hAAAA, "R7 rotate");
    for (int i = 0; i < 3; i++) arbOnce(8'hA0, 16'hAAAA, "R7 sparse");
    // R4 tiers
    arbOnce(8'hFF, 16'hAAAA, "R4 all");
    arbOnce(8'hFC, 16'hAAAA, "R4 mid over low");
    // R8 locked modes on requesting ports
    arbOnce(8'h0F, 16'h00F0 | 16'h0000, "R8 top locked");
    arbOnce(8'h13, 16'h02FC, "R8 mixed");

    // R2 no arbitration while controller busy
    @(negedge clk);
    reqIn = 8'h01; portMode = 16'hAAAA; ctrlIdle = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 idle low no grant", int'(grantValid), 0);

    // R3 hold while higher-tier request appears
    reqIn = 8'h80; ctrlIdle = 1'b1;
    @(negedge clk);
    begin
      int w = 4 + ((mLow + 4) % 4 == 3 ? 3 : 3);
      w = 7;
      chk("R3 low grant taken", int'(grantVec), 1 << w);
      mLow = 3;
    end
    reqIn = 8'h01;
    repeat (3) @(negedge clk);
    chk("R3 hold vec", int'(grantVec), 8'h80);
    chk("R3 hold port", int'(grantPort), 7);
    checkLast("R10 after hold");
    cycleDone = 1'b1; ctrlIdle = 1'b0;
    @(negedge clk);
    cycleDone = 1'b0;
    chk("R3 released", int'(grantValid), 0);

    // Sweep all patterns, all ports newer-style
    for (int i = 0; i < 256; i++) arbOnce(8'(i), 16'hAAAA, "sweep full");
    // Sweep all patterns with mixed and locked modes
    for (int i = 0; i < 256; i++) begin
      logic [15:0] mm = 16'((i * 40503) ^ (i << 5) ^ 16'h6C1B);
      arbOnce(8'(i), mm, "sweep mixed");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule